// File: doc/BRIEF.md
# Parallel ATA PIO Strobe Sequencer

This block drives the read and write strobes of one parallel ATA register or multiword-DMA transfer cycle on a 33 MHz timing clock. A host request names the direction, the channel (0 or 1) and the device on that channel (0 or 1). The block looks up that device's timing in compressed configuration bytes held outside it and plays out three phases. First comes address setup, with the address valid and both strobes high. Next is the active phase, with one strobe low. Last is recovery, with the strobes high again. A one-clock done pulse closes the cycle.

The request port is a valid/ready stream. `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold `req_valid` and its fields until that edge. While a cycle runs, `req_ready` stays low and the block ignores anything on the request port. The drive's wait input is a plain control pin. Each clock it is sampled high during the active phase lengthens that phase by one clock.

The timing bytes are compressed. Each device has an active/recovery byte: the active count sits in the upper nibble, with 0 standing for 16, and the recovery count minus one sits in the lower nibble. The setup length is a 2-bit code in the top of a separate setup byte, and its mapping is not monotonic. On channel 0 each device has its own setup byte. On channel 1 both devices read one shared setup byte, which software programs for the slower of the two devices.

Top module: `ata_pio_strobe_gen`

## Requirements
- R1: While reset is held and directly after it: `req_ready`=1, `addr_valid`=0, `rd_strobe_n`=1, `wr_strobe_n`=1, `cyc_done`=0.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the clock after acceptance through the done clock. While `req_ready` is 0, changes on `req_valid`, `req_write`, `req_dev` and `req_chan` have no effect on the outputs.
- R3: After acceptance the phases run in this order, one clock apart: setup (`addr_valid`=1, both strobes 1), active (`addr_valid`=1, one strobe 0), recovery (`addr_valid`=1, both strobes 1), then one clock with `cyc_done`=1 and `addr_valid`=0. After that clock the block is idle with `req_ready`=1.
- R4: Setup length is taken from bits [7:6] of the selected setup byte: 2'b01 gives 2 clocks, 2'b10 gives 3, 2'b00 gives 4 and 2'b11 gives 5.
- R5: Bits [5:0] of every setup byte have no effect on any output.
- R6: The active length is bits [7:4] of the selected active/recovery byte, read as a count of clocks, where 0 gives 16.
- R7: The recovery length is bits [3:0] of the selected active/recovery byte plus one, so 0 gives 1 clock and 15 gives 16.
- R8: The active/recovery byte for channel c, device d is `act_rec_cfg[8*(2c+d) +: 8]`. For setup, channel 0 device 0 uses `setup_cfg[7:0]`, channel 0 device 1 uses `setup_cfg[15:8]`, and both devices of channel 1 use `setup_cfg[23:16]`.
- R9: Each clock edge that finds `drv_wait`=1 during the active phase adds one clock to that phase, including at its last programmed clock. `drv_wait` has no effect in the other phases.
- R10: The configuration bytes are sampled at acceptance. Later changes to them have no effect on the cycle in progress.
- R11: `rd_strobe_n` goes low only for a read (`req_write`=0), `wr_strobe_n` goes low only for a write, and the two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock (33 MHz in the system) |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_dev | input | 1 | Device select on the channel |
| req_chan | input | 1 | Channel select |
| act_rec_cfg | input | 32 | Four active/recovery bytes, one for each channel/device |
| setup_cfg | input | 24 | Three setup bytes; the code is in the top two bits of each |
| drv_wait | input | 1 | Drive wait; holds the active phase open |
| addr_valid | output | 1 | High from the start of setup to the end of recovery |
| rd_strobe_n | output | 1 | Read strobe, active low |
| wr_strobe_n | output | 1 | Write strobe, active low |
| cyc_done | output | 1 | One-clock pulse after recovery |

## Verification
Two events can land on the same clock: the active phase reaching its last programmed clock, and the drive's wait input being sampled high. The bench raises wait at the first active clock and keeps it up for longer than the programmed active count, so the hold overlaps the terminal count. The per-clock reference model then requires the strobe to stay low for exactly the programmed count plus the number of wait clocks. A second overlap is a request already waiting during the done clock. Back-to-back requests and requests held high through a whole cycle test this, and the model requires acceptance only on the first idle clock.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  localparam int CNT_W = 4;   // phase counter holds length minus one, up to 16 clocks
  localparam int NIB_W = 4;   // width of the active and recovery fields

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_RECOV,
    PH_DONE
  } phase_t;

  // every length is stored as clocks minus one
  typedef struct packed {
    logic [CNT_W-1:0] setup_m1;
    logic [CNT_W-1:0] active_m1;
    logic [CNT_W-1:0] recov_m1;
  } cyc_timing_t;

  // non-monotonic setup code: 01->2, 10->3, 00->4, 11->5 clocks
  function automatic logic [CNT_W-1:0] setup_code_m1(input logic [1:0] code);
    case (code)
      2'b01:   setup_code_m1 = CNT_W'(1);
      2'b10:   setup_code_m1 = CNT_W'(2);
      2'b00:   setup_code_m1 = CNT_W'(3);
      default: setup_code_m1 = CNT_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/ata_pio_timing_decode.sv
module ata_pio_timing_decode
  import ata_pio_pkg::*;
#(
  parameter int NCHAN = 2,
  parameter int NDEV  = 2,
  parameter int BW    = 8,
  localparam int CH_W   = (NCHAN > 1) ? $clog2(NCHAN) : 1,
  localparam int DV_W   = (NDEV > 1) ? $clog2(NDEV) : 1,
  localparam int NSLOT  = NCHAN * NDEV,
  localparam int NSETUP = NDEV + NCHAN - 1
) (
  input  logic [NSLOT*BW-1:0]  act_rec_cfg,
  input  logic [NSETUP*BW-1:0] setup_cfg,
  input  logic [CH_W-1:0]      sel_chan,
  input  logic [DV_W-1:0]      sel_dev,
  output cyc_timing_t          timing
);

  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  cyc_timing_t [NSLOT-1:0] slot_tim;

  // one decoder per device slot; channel 0 owns a setup byte per device,
  // every later channel shares one setup byte across its devices
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam int CH = g / NDEV;
    localparam int DV = g % NDEV;
    localparam int SI = (CH == 0) ? DV : (NDEV + CH - 1);

    logic [NIB_W-1:0] act_nib;
    logic [NIB_W-1:0] rec_nib;
    logic [1:0]       code;

    assign act_nib = act_rec_cfg[g*BW+NIB_W +: NIB_W];
    assign rec_nib = act_rec_cfg[g*BW +: NIB_W];
    assign code    = setup_cfg[SI*BW+BW-2 +: 2];

    // active nibble 0 means 16 clocks: n-1 modulo 16 covers both cases
    assign slot_tim[g] = '{setup_m1:  setup_code_m1(code),
                           active_m1: CNT_W'(act_nib - NIB_W'(1)),
                           recov_m1:  CNT_W'(rec_nib)};
  end

  logic [IDX_W-1:0] sel_idx;

  always_comb begin
    sel_idx = IDX_W'(int'(sel_chan) * NDEV + int'(sel_dev));
    timing  = slot_tim[sel_idx];
  end

endmodule

// File: rtl/ata_pio_phase_seq.sv
module ata_pio_phase_seq
  import ata_pio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_write,
  input  cyc_timing_t timing,
  input  logic        drv_wait,
  output phase_t      phase,
  output logic        wr_cycle
);

  logic [CNT_W-1:0] cnt;
  cyc_timing_t      tim_q;
  logic             last;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      tim_q    <= '0;
      wr_cycle <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          tim_q    <= timing;
          wr_cycle <= is_write;
          cnt      <= timing.setup_m1;
          phase    <= PH_SETUP;
        end
        PH_SETUP: if (last) begin
          cnt   <= tim_q.active_m1;
          phase <= PH_ACTIVE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        PH_ACTIVE: if (!drv_wait) begin
          if (last) begin
            cnt   <= tim_q.recov_m1;
            phase <= PH_RECOV;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_RECOV: if (last) begin
          phase <= PH_DONE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        PH_DONE:  phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACTIVE && drv_wait) |=> (phase == PH_ACTIVE && $stable(cnt))); // R9

  AST_ACTIVE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACTIVE && $past(phase) != PH_ACTIVE) |-> $past(phase) == PH_SETUP); // R3

  AST_DONE_AFTER_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE) |-> $past(phase) == PH_RECOV); // R3

  AST_TIMING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> ($stable(tim_q) && $stable(wr_cycle))); // R10

endmodule

// File: rtl/ata_pio_strobe_gen.sv
module ata_pio_strobe_gen
  import ata_pio_pkg::*;
#(
  parameter int NCHAN = 2,
  parameter int NDEV  = 2,
  parameter int BW    = 8,
  localparam int CH_W   = (NCHAN > 1) ? $clog2(NCHAN) : 1,
  localparam int DV_W   = (NDEV > 1) ? $clog2(NDEV) : 1,
  localparam int NSLOT  = NCHAN * NDEV,
  localparam int NSETUP = NDEV + NCHAN - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [DV_W-1:0]      req_dev,
  input  logic [CH_W-1:0]      req_chan,
  input  logic [NSLOT*BW-1:0]  act_rec_cfg,
  input  logic [NSETUP*BW-1:0] setup_cfg,
  input  logic                 drv_wait,
  output logic                 addr_valid,
  output logic                 rd_strobe_n,
  output logic                 wr_strobe_n,
  output logic                 cyc_done
);

  cyc_timing_t sel_timing;
  phase_t      phase;
  logic        wr_cycle;
  logic        accept;

  ata_pio_timing_decode #(
    .NCHAN(NCHAN),
    .NDEV (NDEV),
    .BW   (BW)
  ) decode_i (
    .act_rec_cfg(act_rec_cfg),
    .setup_cfg  (setup_cfg),
    .sel_chan   (req_chan),
    .sel_dev    (req_dev),
    .timing     (sel_timing)
  );

  assign accept = req_valid && req_ready;

  ata_pio_phase_seq seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .is_write(req_write),
    .timing  (sel_timing),
    .drv_wait(drv_wait),
    .phase   (phase),
    .wr_cycle(wr_cycle)
  );

  always_comb begin
    req_ready   = (phase == PH_IDLE);
    addr_valid  = (phase == PH_SETUP) || (phase == PH_ACTIVE) || (phase == PH_RECOV);
    rd_strobe_n = !((phase == PH_ACTIVE) && !wr_cycle);
    wr_strobe_n = !((phase == PH_ACTIVE) && wr_cycle);
    cyc_done    = (phase == PH_DONE);
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && addr_valid)); // R2

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~rd_strobe_n, ~wr_strobe_n}) <= 1); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> (!cyc_done && req_ready)); // R3

  AST_STROBE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_strobe_n || !wr_strobe_n) |-> addr_valid); // R3

endmodule

// File: tb/ata_pio_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module ata_pio_strobe_gen_tb_top;

  localparam real CLK_PERIOD = 5.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [0:0]  req_dev = '0;
  logic [0:0]  req_chan = '0;
  logic [31:0] act_rec_cfg = '0;
  logic [23:0] setup_cfg = '0;
  logic        drv_wait = 1'b0;
  logic        addr_valid, rd_strobe_n, wr_strobe_n, cyc_done;

  always #(CLK_PERIOD/2.0) clk = ~clk;

  ata_pio_strobe_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_dev(req_dev), .req_chan(req_chan),
    .act_rec_cfg(act_rec_cfg), .setup_cfg(setup_cfg), .drv_wait(drv_wait),
    .addr_valid(addr_valid), .rd_strobe_n(rd_strobe_n),
    .wr_strobe_n(wr_strobe_n), .cyc_done(cyc_done)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  // reference model: 0 idle, 1 setup, 2 active, 3 recovery, 4 done
  int m_phase = 0;
  int m_rem   = 0;
  int m_s, m_a, m_r;
  bit m_wr    = 1'b0;

  function automatic int setup_len(input logic [7:0] b);
    case (b[7:6])
      2'b01:   return 2;
      2'b10:   return 3;
      2'b00:   return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int act_len(input logic [7:0] b);
    return (b[7:4] == 0) ? 16 : int'(b[7:4]);
  endfunction

  function automatic int rec_len(input logic [7:0] b);
    return int'(b[3:0]) + 1;
  endfunction

  function automatic logic [7:0] setup_byte(input bit c, input bit d);
    if (c) return setup_cfg[23:16];
    return d ? setup_cfg[15:8] : setup_cfg[7:0];
  endfunction

  function automatic logic [7:0] ar_byte(input bit c, input bit d);
    int i;
    i = 2 * int'(c) + int'(d);
    return act_rec_cfg[8*i +: 8];
  endfunction

  task automatic model_step();
    case (m_phase)
      0: if (req_valid) begin
        m_s = setup_len(setup_byte(req_chan[0], req_dev[0]));
        m_a = act_len(ar_byte(req_chan[0], req_dev[0]));
        m_r = rec_len(ar_byte(req_chan[0], req_dev[0]));
        m_wr = req_write;
        m_phase = 1; m_rem = m_s;
      end
      1: if (m_rem == 1) begin m_phase = 2; m_rem = m_a; end else m_rem--;
      2: if (!drv_wait) begin
        if (m_rem == 1) begin m_phase = 3; m_rem = m_r; end else m_rem--;
      end
      3: if (m_rem == 1) m_phase = 4; else m_rem--;
      default: m_phase = 0;
    endcase
  endtask

  task automatic compare();
    logic [4:0] exp_v, act_v;
    exp_v = {m_phase == 0, m_phase inside {1, 2, 3},
             !(m_phase == 2 && !m_wr), !(m_phase == 2 && m_wr), m_phase == 4};
    act_v = {req_ready, addr_valid, rd_strobe_n, wr_strobe_n, cyc_done};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: {ready,addr,rd_n,wr_n,done} actual %b expected %b at %0t",
               cur_req, act_v, exp_v, $time);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare();
  endtask

  // one full transfer; returns nothing, checks phase lengths at the end
  task automatic do_cycle(input bit w, input bit d, input bit c, input int nwait,
                          input bit scramble, input bit hold, input string tag);
    int s, a, r, lo, busy, waited, guard;
    logic [31:0] ar_save;
    logic [23:0] su_save;
    s = setup_len(setup_byte(c, d));
    a = act_len(ar_byte(c, d));
    r = rec_len(ar_byte(c, d));
    cur_req = tag;
    req_write = w; req_dev = d; req_chan = c; req_valid = 1'b1;
    ar_save = act_rec_cfg; su_save = setup_cfg;
    lo = 0; busy = 0; waited = 0; guard = 0;
    tick();
    if (hold) begin
      req_write = ~w; req_dev = ~d; req_chan = ~c;
    end else begin
      req_valid = 1'b0;
    end
    if (scramble) begin
      act_rec_cfg = $urandom; setup_cfg = 24'($urandom);
    end
    while (m_phase != 0 && guard < 300) begin
      drv_wait = (m_phase == 2 && waited < nwait);
      if (drv_wait) waited++;
      if (hold && m_phase == 4) req_valid = 1'b0;
      if (!rd_strobe_n || !wr_strobe_n) lo++;
      if (!req_ready) busy++;
      tick();
      guard++;
    end
    drv_wait = 1'b0;
    act_rec_cfg = ar_save; setup_cfg = su_save;
    check_int({tag, " strobe-low clocks"}, lo, a + nwait);
    check_int({tag, " busy clocks"}, busy, s + a + nwait + r + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset values
    cur_req = "R1";
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    tick(); tick();

    // R3 R4 R6 R7: read on channel 0 device 0, code 01 -> 2, active 3, recovery 2
    setup_cfg   = {8'h00, 8'h80, 8'h40};
    act_rec_cfg = {8'h1A, 8'h52, 8'h0F, 8'h31};
    do_cycle(1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R3_R4_R6_R7");
    tick();

    // R6 R7 R11: write, code 10 -> 3, active 0 -> 16, recovery 15 -> 16
    do_cycle(1'b1, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R6_R7_R11");
    tick();

    // R8 R4: channel 1 shares setup byte 2 (code 00 -> 4)
    do_cycle(1'b0, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R8_R4");
    setup_cfg[23:16] = 8'hC0;  // code 11 -> 5 for both devices
    do_cycle(1'b1, 1'b1, 1'b1, 0, 1'b0, 1'b0, "R8_R4_c1d1");
    do_cycle(1'b0, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R8_c1d0_shared");
    tick();

    // R5: low setup bits set, same code 01 must give the same timing
    setup_cfg[7:0] = 8'h7F;
    do_cycle(1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R5");
    setup_cfg[7:0] = 8'h40;
    tick();

    // R9: wait covers the final active clock (active 3, wait 5)
    do_cycle(1'b0, 1'b0, 1'b0, 5, 1'b0, 1'b0, "R9_overlap");
    do_cycle(1'b1, 1'b0, 1'b1, 2, 1'b0, 1'b0, "R9");

    // R10: configuration scrambled during the cycle
    for (int k = 0; k < 3; k++)
      do_cycle(k[0], k[1], 1'b0, 0, 1'b1, 1'b0, "R10");

    // R2: request held high with changed fields during the cycle
    do_cycle(1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b1, "R2");
    tick();
    // R2: back-to-back requests, accepted on the first idle clock
    do_cycle(1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R2_b2b");
    do_cycle(1'b0, 1'b1, 1'b1, 0, 1'b0, 1'b0, "R2_b2b");
    cur_req = "R9_idle";
    drv_wait = 1'b1;
    tick(); tick();
    drv_wait = 1'b0;
    tick();

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule